// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add

This block computes a*b+c on three binary32 operands and rounds only once, at the end, to nearest with ties to even. Subnormal operands are read as zeros. Results that would be subnormal are flushed to a zero of the result's sign. The datapath first unpacks the operands and forms the 48-bit significand product. It then places the product and the addend in a fixed 64-bit window, shifts the operand with the smaller exponent right, and keeps a sticky bit for every bit that falls off the bottom. After that it adds or subtracts, normalizes with a leading-zero count, rounds and repacks. Special operand classes skip the datapath and produce their result directly.

The unit is a three-stage pipeline that accepts one operation per clock and has no stall. The caller presents a, b and c with a valid strobe. The result appears with its own valid strobe a fixed number of cycles later. There is no backpressure, no flag output and only one rounding mode.

Top module: `fma_sp_core`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` delayed by three rising edges, so one operation is accepted on every cycle. While `rst_ni` is low, `out_valid_o` and `out_res_o` are 0.
- R2: If any operand is a NaN (exponent field 0xFF, fraction nonzero), the result is the quiet NaN 0x7FC00000. This is the only NaN encoding the unit ever outputs.
- R3: If a or b is infinite, the result depends on the other factor and on c:
  - If the other factor is zero, the result is 0x7FC00000.
  - If c is infinite with a sign opposite to the product sign sa^sb, the result is 0x7FC00000.
  - Otherwise the result is an infinity carrying the product sign.
- R4: If a and b are finite and c is infinite, the result is c, bit for bit.
- R5: An operand whose exponent field is 0 is treated as a zero of its own sign, whatever its fraction. This also applies next to an infinity, so infinity times a subnormal gives 0x7FC00000.
- R6: If c is zero, the result is the product a*b rounded once. If a or b is also zero, the result is a zero with sign sa^sb.
- R7: If a or b is zero and c is finite and nonzero, the result is c, bit for bit.
- R8: Alignment works as follows:
  - The product significand sits at bit 14 and the addend significand at bit 37 of the 64-bit window.
  - The side with the smaller exponent shifts right by the exponent difference, and a shift of 64 or more clears it.
  - Every bit shifted out feeds the sticky bit.
  - On subtraction, one extra unit is subtracted when the sticky bit is set and the product exponent is the larger.
- R9: If the sign-differing subtraction goes negative (bit 63 set), the magnitude is negated and the result sign flips. An exactly zero final significand gives +0 (0x00000000).
- R10: Rounding is to nearest, ties to even, using the bits below the rounding position together with the sticky bit. A carry out of 24 significand bits shifts right one place and raises the exponent.
- R11: A final unbiased exponent above 127 gives an infinity with the result sign (0x7F800000 or 0xFF800000).
- R12: A final unbiased exponent of -127 or less gives a zero with the result sign. No result has a zero exponent field with a nonzero fraction.
- R13: `out_res_o` keeps its value on every cycle in which `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are presented this cycle |
| a_i | input | 32 | Multiplicand, binary32 |
| b_i | input | 32 | Multiplier, binary32 |
| c_i | input | 32 | Addend, binary32 |
| out_valid_o | output | 1 | Result is valid this cycle |
| out_res_o | output | 32 | Rounded result a*b+c, binary32 |

## Verification
The hardest cases to reach through the ports are deep cancellation and the sticky borrow. In deep cancellation, c almost exactly cancels the product and normalization has to shift left by tens of bits. In the sticky borrow, bits that have already fallen off the bottom of the window change a round-to-nearest decision. Uniformly random operands almost never produce either case. The stimulus therefore takes the correctly rounded product, flips its sign and perturbs its low fraction bits to form c. It also places c a random 20 to 80 binades below the product, so the addend drops partly or wholly below the window. Directed cases add an exact tie, a rounding carry to the next binade, overflow, underflow and every special class.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int PROD_W   = 2 * SIG_W;
  localparam int WIN_W    = 64;
  localparam int PROD_SHL = WIN_W - 2 - PROD_W;        // two spare top bits
  localparam int ADD_SHL  = PROD_SHL + FRAC_W;         // addend hidden bit meets product unit bit
  localparam int NORM_LZ  = WIN_W - 1 - (ADD_SHL + FRAC_W);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int SE_W     = EXP_W + 3;
  localparam int LZ_W     = $clog2(WIN_W + 1);
  localparam int SH_W     = $clog2(WIN_W);
  localparam int RSH_W    = 2;

  localparam logic signed [SE_W-1:0] BIAS_S = SE_W'(BIAS);
  localparam logic signed [SE_W-1:0] EMIN_S = SE_W'(-BIAS);
  localparam logic signed [SE_W-1:0] NORM_S = SE_W'(NORM_LZ);
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic                    special;
    logic [WORD_W-1:0]       spec_res;
    logic                    sign_p;
    logic                    sign_c;
    logic signed [SE_W-1:0]  exp_p;
    logic signed [SE_W-1:0]  exp_c;
    logic [PROD_W-1:0]       prod;
    logic [SIG_W-1:0]        sig_c;
  } prep_t;

  typedef struct packed {
    logic                    special;
    logic [WORD_W-1:0]       spec_res;
    logic                    sign;
    logic signed [SE_W-1:0]  exp;
    logic [WIN_W-1:0]        mag;
    logic                    sticky;
    logic [LZ_W-1:0]         lz;
  } sum_t;

  function automatic logic signed [SE_W-1:0] unbias(input logic [EXP_W-1:0] e);
    return $signed({{(SE_W-EXP_W){1'b0}}, e}) - BIAS_S;
  endfunction
endpackage

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter  int W  = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++)
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
  end
endmodule

// File: rtl/fma_unpack.sv
module fma_unpack
  import fma_sp_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] c_i,
  output prep_t             prep_o
);
  localparam int NOPS = 3;

  logic [WORD_W-1:0] op     [NOPS];
  logic [EXP_W-1:0]  ex     [NOPS];
  logic [SIG_W-1:0]  sig    [NOPS];
  logic [NOPS-1:0]   is_zero, is_inf, is_nan, sgn;

  assign op[0] = a_i;
  assign op[1] = b_i;
  assign op[2] = c_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    logic [FRAC_W-1:0] frac;
    assign ex[g]      = op[g][WORD_W-2 -: EXP_W];
    assign frac       = op[g][FRAC_W-1:0];
    assign sgn[g]     = op[g][WORD_W-1];
    assign is_zero[g] = (ex[g] == '0);            // subnormals read as zero
    assign is_inf[g]  = (&ex[g]) && (frac == '0);
    assign is_nan[g]  = (&ex[g]) && (frac != '0);
    assign sig[g]     = is_zero[g] ? '0 : {1'b1, frac};
  end

  logic sign_p;
  assign sign_p = sgn[0] ^ sgn[1];

  always_comb begin
    prep_o.special  = 1'b1;
    prep_o.spec_res = '0;
    if (|is_nan) begin
      prep_o.spec_res = QNAN;
    end else if (is_inf[0] || is_inf[1]) begin
      if (is_zero[0] || is_zero[1])          prep_o.spec_res = QNAN;
      else if (is_inf[2] && sgn[2] != sign_p) prep_o.spec_res = QNAN;
      else prep_o.spec_res = {sign_p, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (is_inf[2]) begin
      prep_o.spec_res = c_i;
    end else if (is_zero[0] || is_zero[1]) begin
      prep_o.spec_res = is_zero[2] ? {sign_p, {(WORD_W-1){1'b0}}} : c_i;
    end else begin
      prep_o.special = 1'b0;
    end
  end

  always_comb begin
    prep_o.sign_p = sign_p;
    prep_o.sign_c = sgn[2];
    prep_o.prod   = sig[0] * sig[1];
    prep_o.exp_p  = unbias(ex[0]) + unbias(ex[1]);
    // zero addend: pin its exponent to the product so the product is never shifted
    prep_o.exp_c  = is_zero[2] ? prep_o.exp_p : unbias(ex[2]);
    prep_o.sig_c  = sig[2];
  end
endmodule

// File: rtl/fma_align_add.sv
module fma_align_add
  import fma_sp_pkg::*;
(
  input  prep_t p_i,
  output sum_t  s_o
);
  logic [WIN_W-1:0]       win_p, win_c, src, shifted, lost_mask;
  logic [WIN_W-1:0]       al_p, al_c, raw;
  logic signed [SE_W-1:0] diff;
  logic [SE_W-1:0]        shamt;
  logic                   p_big, far, sticky, eff_sub, borrow, neg;

  assign win_p = {{(WIN_W-PROD_W){1'b0}}, p_i.prod} << PROD_SHL;
  assign win_c = {{(WIN_W-SIG_W){1'b0}}, p_i.sig_c} << ADD_SHL;

  assign diff  = p_i.exp_p - p_i.exp_c;
  assign p_big = (diff > 0);
  assign shamt = p_big ? diff : -diff;
  assign far   = (shamt >= SE_W'(WIN_W));

  assign src       = p_big ? win_c : win_p;
  assign shifted   = far ? '0 : (src >> shamt[SH_W-1:0]);
  assign lost_mask = far ? '1 : ~({WIN_W{1'b1}} << shamt[SH_W-1:0]);
  assign sticky    = |(src & lost_mask);

  assign al_p = p_big ? win_p : shifted;
  assign al_c = p_big ? shifted : win_c;

  assign eff_sub = p_i.sign_p ^ p_i.sign_c;
  assign borrow  = eff_sub & sticky & p_big;
  assign raw     = eff_sub ? (al_p - al_c - WIN_W'(borrow)) : (al_p + al_c);
  assign neg     = raw[WIN_W-1];

  assign s_o.special  = p_i.special;
  assign s_o.spec_res = p_i.spec_res;
  assign s_o.sign     = p_i.sign_p ^ neg;
  assign s_o.exp      = p_big ? p_i.exp_p : p_i.exp_c;
  assign s_o.mag      = neg ? (~raw + WIN_W'(1)) : raw;
  assign s_o.sticky   = sticky;

  fma_lzc #(.W(WIN_W)) u_lzc (
    .vec_i (s_o.mag),
    .cnt_o (s_o.lz)
  );
endmodule

// File: rtl/fma_round_pack.sv
module fma_round_pack
  import fma_sp_pkg::*;
(
  input  sum_t              s_i,
  output logic [WORD_W-1:0] res_o
);
  logic signed [SE_W-1:0] lz_s, adj, exp_n, exp_r, biased;
  logic [WIN_W-1:0]       norm, low_mask, trunc, half, kept;
  logic [LZ_W-1:0]        pos, lsh;
  logic [RSH_W-1:0]       rsh;
  logic [SIG_W:0]         mant, mant_f;
  logic                   last, rup, carry;
  logic                   unused_ok;

  always_comb begin
    lz_s  = $signed({{(SE_W-LZ_W){1'b0}}, s_i.lz});
    adj   = NORM_S - lz_s;
    exp_n = s_i.exp + adj;
    lsh   = s_i.lz - LZ_W'(NORM_LZ);
    if (adj < 0) begin
      norm = s_i.mag << lsh;
      rsh  = '0;
    end else begin
      norm = s_i.mag;
      rsh  = adj[RSH_W-1:0];
    end
    pos      = LZ_W'(ADD_SHL) + LZ_W'(rsh);
    low_mask = ~({WIN_W{1'b1}} << pos);
    trunc    = (norm & low_mask) | WIN_W'(s_i.sticky);
    half     = WIN_W'(1) << (pos - LZ_W'(1));
    kept     = norm >> pos;
    last     = kept[0];
    rup      = (trunc > half) || ((trunc == half) && last);
    mant     = kept[SIG_W:0] + (SIG_W+1)'(rup);
    carry    = mant[SIG_W];
    mant_f   = carry ? (mant >> 1) : mant;
    exp_r    = exp_n + (carry ? SE_W'(1) : SE_W'(0));
    biased   = exp_r + BIAS_S;

    if (s_i.special)          res_o = s_i.spec_res;
    else if (mant_f == '0)    res_o = '0;
    else if (exp_r > BIAS_S)  res_o = {s_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (exp_r <= EMIN_S) res_o = {s_i.sign, {(WORD_W-1){1'b0}}};
    else                      res_o = {s_i.sign, biased[EXP_W-1:0], mant_f[FRAC_W-1:0]};
  end

  assign unused_ok = ^{kept[WIN_W-1:SIG_W+1], biased[SE_W-1:EXP_W], adj[SE_W-1:RSH_W], mant_f[SIG_W:FRAC_W]};
endmodule

// File: rtl/fma_sp_core.sv
module fma_sp_core
  import fma_sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] c_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_res_o
);
  prep_t             prep_d, prep_q;
  sum_t              sum_d, sum_q;
  logic [WORD_W-1:0] res_d;
  logic              v1_q, v2_q;

  fma_unpack u_unpack (
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .prep_o (prep_d)
  );

  fma_align_add u_align_add (
    .p_i (prep_q),
    .s_o (sum_d)
  );

  fma_round_pack u_round_pack (
    .s_i   (sum_q),
    .res_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
      prep_q      <= '0;
      sum_q       <= '0;
      out_res_o   <= '0;
    end else begin
      v1_q        <= in_valid_i;
      v2_q        <= v1_q;
      out_valid_o <= v2_q;
      if (in_valid_i) prep_q    <= prep_d;
      if (v1_q)       sum_q     <= sum_d;
      if (v2_q)       out_res_o <= res_d;
    end
  end
endmodule

// File: rtl/fma_sp_core_chk.sv
module fma_sp_core_chk
  import fma_sp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] c_i,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_res_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic a_fin, b_fin, c_inf, c_fin_nz, ab_zero, only_c_inf, zero_prod_pass;
  assign a_fin          = ~&a_i[WORD_W-2 -: EXP_W];
  assign b_fin          = ~&b_i[WORD_W-2 -: EXP_W];
  assign c_inf          = (&c_i[WORD_W-2 -: EXP_W]) && (c_i[FRAC_W-1:0] == '0);
  assign c_fin_nz       = ~&c_i[WORD_W-2 -: EXP_W] && (c_i[WORD_W-2 -: EXP_W] != '0);
  assign ab_zero        = (a_i[WORD_W-2 -: EXP_W] == '0) || (b_i[WORD_W-2 -: EXP_W] == '0);
  assign only_c_inf     = a_fin && b_fin && c_inf;
  assign zero_prod_pass = a_fin && b_fin && ab_zero && c_fin_nz;

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  a_r2_canonical_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (&out_res_o[WORD_W-2 -: EXP_W]) && (out_res_o[FRAC_W-1:0] != '0))
      |-> (out_res_o == QNAN));

  a_r4_inf_addend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && out_valid_o && $past(only_c_inf, 3)) |-> (out_res_o == $past(c_i, 3)));

  a_r7_zero_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && out_valid_o && $past(zero_prod_pass, 3)) |-> (out_res_o == $past(c_i, 3)));

  a_r12_no_subnormal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !((out_res_o[WORD_W-2 -: EXP_W] == '0) && (out_res_o[FRAC_W-1:0] != '0)));

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_res_o));
endmodule

bind fma_sp_core fma_sp_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .c_i         (c_i),
  .out_valid_o (out_valid_o),
  .out_res_o   (out_res_o)
);

// File: tb/fma_sp_core_bench.sv
module fma_sp_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic        out_valid_o;
  logic [31:0] out_res_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  fma_sp_core u_fma_sp_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .c_i         (c_i),
    .out_valid_o (out_valid_o),
    .out_res_o   (out_res_o)
  );

  localparam logic [31:0] QN = 32'h7FC00000;

  // Behavioural reference built from R2..R12, 64-bit integer arithmetic
  function automatic logic [31:0] ref_fma(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    bit za = (a[30:23] == 0), zb = (b[30:23] == 0), zc = (c[30:23] == 0);
    bit ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bit ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    bit ic = (c[30:23] == 8'hFF) && (c[22:0] == 0);
    bit na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bit nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    bit nc = (c[30:23] == 8'hFF) && (c[22:0] != 0);
    logic sp = a[31] ^ b[31];
    logic sc = c[31];
    logic sgn;
    logic [63:0] mp, mc, sum, trunc, half;
    logic [24:0] mant;
    int em, ec, diff, k, ex, ov, lz, pos;
    bit st;
    if (na || nb || nc) return QN;
    if (ia || ib) begin
      if (za || zb) return QN;
      if (ic && sc != sp) return QN;
      return {sp, 8'hFF, 23'd0};
    end
    if (ic) return c;
    if (za || zb) return zc ? {sp, 31'd0} : c;
    mp = (64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]})) << 14;
    em = int'(a[30:23]) + int'(b[30:23]) - 254;
    if (zc) begin mc = 0; ec = em; end
    else begin mc = 64'({1'b1, c[22:0]}) << 37; ec = int'(c[30:23]) - 127; end
    diff = em - ec;
    st = 0;
    if (diff > 0) begin
      if (diff >= 64) begin st = (mc != 0); mc = 0; end
      else begin st = ((mc & ((64'd1 << diff) - 1)) != 0); mc = mc >> diff; end
      ex = em;
    end else begin
      k = -diff;
      if (k >= 64) begin st = (mp != 0); mp = 0; end
      else begin st = ((mp & ((64'd1 << k) - 1)) != 0); mp = mp >> k; end
      ex = ec;
    end
    sgn = sp;
    if (sp == sc) sum = mp + mc;
    else sum = mp - mc - ((st && diff > 0) ? 64'd1 : 64'd0);
    if (sum[63]) begin sum = -sum; sgn = ~sgn; end
    lz = 64;
    for (int i = 63; i >= 0; i--) if (sum[i]) begin lz = 63 - i; break; end
    ov = 3 - lz;
    ex = ex + ov;
    if (ov < 0) begin sum = sum << (-ov); ov = 0; end
    pos = 37 + ov;
    trunc = (sum & ((64'd1 << pos) - 1)) | 64'(st);
    half = 64'd1 << (pos - 1);
    if (trunc > half || (trunc == half && sum[pos])) sum = sum + (64'd1 << pos);
    mant = 25'(sum >> pos);
    if (mant[24]) begin mant = mant >> 1; ex = ex + 1; end
    if (mant == 0) return 32'h0;
    if (ex > 127) return {sgn, 8'hFF, 23'd0};
    if (ex <= -127) return {sgn, 31'd0};
    return {sgn, 8'(ex + 127), mant[22:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Pipeline model of expected results
  logic        cur_hand = 0;
  logic [31:0] cur_e = '0;
  string       cur_t = "";
  logic        q_v [3];
  logic [31:0] q_e [3];
  string       q_t [3];
  logic [31:0] last_res = '0;
  bit          have_last = 0;

  initial for (int i = 0; i < 3; i++) begin q_v[i] = 0; q_e[i] = '0; q_t[i] = ""; end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) q_v[i] = 0;
    end else begin
      q_v[2] = q_v[1]; q_e[2] = q_e[1]; q_t[2] = q_t[1];
      q_v[1] = q_v[0]; q_e[1] = q_e[0]; q_t[1] = q_t[0];
      q_v[0] = in_valid_i; q_e[0] = cur_e; q_t[0] = cur_t;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(out_valid_o == 1'b0 && out_res_o == 32'h0, "R1 reset state", {31'd0, out_valid_o} ^ out_res_o, 32'h0);
    end else if (!done) begin
      chk(out_valid_o == q_v[2], "R1 valid latency", {31'd0, out_valid_o}, {31'd0, q_v[2]});
      if (q_v[2]) begin
        chk(out_res_o == q_e[2], q_t[2], out_res_o, q_e[2]);
        last_res = q_e[2];
        have_last = 1;
      end else if (have_last) begin
        chk(out_res_o == last_res, "R13 hold while idle", out_res_o, last_res);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input bit hand, input logic [31:0] hv, input string tag);
    @(negedge clk_i);
    a_i = a; b_i = b; c_i = c;
    in_valid_i = 1'b1;
    cur_e = hand ? hv : ref_fma(a, b, c);
    cur_t = tag;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      a_i = $urandom; b_i = $urandom; c_i = $urandom;
    end
  endtask

  function automatic logic [31:0] rnd_op();
    int k = int'($urandom % 16);
    logic s = 1'($urandom);
    logic [22:0] f = 23'($urandom);
    case (k)
      0:       return {s, 31'd0};
      1:       return {s, 8'd0, f | 23'd1};
      2:       return {s, 8'hFF, 23'd0};
      3:       return {s, 8'hFF, f | 23'd1};
      4, 5:    return {s, 8'(1 + $urandom % 254), f};
      default: return {s, 8'(110 + $urandom % 36), f};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, p;
    int e;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // directed, hand-computed expected values
    issue(32'h3F800000, 32'h3F800000, 32'h3F800000, 1, 32'h40000000, "R6 1*1+1");
    issue(32'h3FC00000, 32'h3FC00000, 32'h00000000, 1, 32'h40100000, "R6 c zero gives rounded product");
    issue(32'h80000000, 32'h3F800000, 32'h00000000, 1, 32'h80000000, "R6 signed zero from zeros");
    issue(32'h7FA00000, 32'h3F800000, 32'h3F800000, 1, QN, "R2 signalling nan in");
    issue(32'h3F800000, 32'h3F800000, 32'hFFC00001, 1, QN, "R2 nan addend");
    issue(32'h7F800000, 32'h00000000, 32'h3F800000, 1, QN, "R3 inf times zero");
    issue(32'h7F800000, 32'h3F800000, 32'hFF800000, 1, QN, "R3 inf minus inf");
    issue(32'h7F800000, 32'hBF800000, 32'h3F800000, 1, 32'hFF800000, "R3 signed inf");
    issue(32'h3F800000, 32'h3F800000, 32'hFF800000, 1, 32'hFF800000, "R4 addend inf");
    issue(32'h7F800000, 32'h00000010, 32'h3F800000, 1, QN, "R5 inf times subnormal");
    issue(32'h3F800000, 32'h40000000, 32'h00000005, 1, 32'h40000000, "R5 subnormal addend");
    issue(32'h00000001, 32'h3F800000, 32'h40000000, 1, 32'h40000000, "R7 zero product passes c");
    issue(32'h3F800000, 32'h3F800000, 32'hB0800000, 1, 32'h3F800000, "R8 small addend subtract");
    issue(32'h3F800000, 32'h3F800000, 32'h9C800000, 1, 32'h3F800000, "R8 far addend sticky borrow");
    issue(32'h3F800000, 32'h3F800000, 32'hC0000000, 1, 32'hBF800000, "R9 negative difference");
    issue(32'h40000000, 32'h40400000, 32'hC0C00000, 1, 32'h00000000, "R9 exact cancel to +0");
    issue(32'h3F800000, 32'h3F800000, 32'h33800000, 1, 32'h3F800000, "R10 tie to even down");
    issue(32'h3F800000, 32'h3F800000, 32'h34400000, 1, 32'h3F800002, "R10 above half up");
    issue(32'h3FFFFFFF, 32'h3F800000, 32'h33800000, 1, 32'h40000000, "R10 rounding carry");
    issue(32'h7F7FFFFF, 32'h40000000, 32'h00000000, 1, 32'h7F800000, "R11 overflow +inf");
    issue(32'h7F7FFFFF, 32'hC0000000, 32'h00000000, 1, 32'hFF800000, "R11 overflow -inf");
    issue(32'h0D800000, 32'h8D800000, 32'h00000000, 1, 32'h80000000, "R12 underflow signed zero");
    idle(5);

    // random, biased toward cancellation and far addends
    for (int n = 0; n < 3000; n++) begin
      a = rnd_op();
      b = rnd_op();
      case ($urandom % 4)
        0: c = rnd_op();
        1: begin
          p = ref_fma(a, b, 32'h0);
          c = {~p[31], p[30:0]} ^ (32'($urandom % 8));
        end
        2: begin
          e = int'(a[30:23]) + int'(b[30:23]) - 127 - (20 + int'($urandom % 60));
          if (e < 1) e = 1;
          if (e > 254) e = 254;
          c = {1'($urandom), 8'(e), 23'($urandom)};
        end
        default: c = {~(a[31] ^ b[31]), rnd_op() & 32'h7FFFFFFF};
      endcase
      issue(a, b, c, 0, 32'h0, "R10 random vs model (R8 R9 R11 R12)");
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule